// File: doc/BRIEF.md
# Colour Palette Register Port with Auto-Increment

This block gives a CPU byte-wide access to a 128-byte colour palette memory through two register pairs. Each pair has an index register and a data register. The background pair reaches palette bytes 0 to 63. The object pair reaches bytes 64 to 127. Software writes an index, optionally with auto-increment enabled, and then streams colour bytes through the data register. When auto-increment is on, the index steps forward after each data write. Writing an index also fetches the palette byte at that position into the data register, so a read that follows at once returns the stored colour.

A second, independent read port lets the renderer fetch any palette byte by its 7-bit address. A `color_mode` input gates the whole CPU side. While it is low, the block acts as if the registers were absent: CPU writes have no effect and CPU reads return all ones.

Top module: `pal_port`

## Requirements
- R1: After synchronous reset, all four registers read 0x00, and `cpu_rvalid` and `rnd_valid` are low in the first cycle after reset.
- R2: `cpu_sel` picks the register. 0 is the background index, 1 is background data, 2 is the object index and 3 is object data. An index register reads as {auto-increment bit 7, bit 6 = 0, index in bits 5..0}.
- R3: Writing an index register loads that pair's data register with the palette byte at the new index. A data read in the very next cycle returns that byte.
- R4: A data write stores the byte at the pair's current index, and the data register then reads back the written byte.
- R5: When bit 7 of the index register is set, each data write advances the 6-bit index by one. The index wraps from 63 to 0 and bit 7 is kept. When bit 7 is clear, the index does not move.
- R6: The background pair addresses palette byte `index`. The object pair addresses palette byte 64 + `index`. Renderer address bit 6 selects the object half.
- R7: While `color_mode` is 0, CPU writes change neither the registers nor the palette, and every CPU read returns 0xFF.
- R8: `cpu_rdata` is valid, with `cpu_rvalid` high, in the cycle after `cpu_rd`. `cpu_rvalid` is low otherwise.
- R9: `rnd_data` holds the palette byte at `rnd_addr`, with `rnd_valid` high, in the cycle after `rnd_rd`.
- R10: If a CPU data write and a renderer read hit the same palette byte in one cycle, the renderer gets the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| color_mode | input | 1 | 1 enables the CPU registers; 0 makes them inert |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe |
| cpu_sel | input | 2 | Register select (see R2) |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Registered CPU read byte |
| cpu_rvalid | output | 1 | cpu_rdata valid |
| rnd_rd | input | 1 | Renderer read strobe |
| rnd_addr | input | 7 | Renderer palette byte address |
| rnd_data | output | 8 | Registered renderer read byte |
| rnd_valid | output | 1 | rnd_data valid |

## Verification
The bench fills the whole palette by streaming 64 bytes through each pair, so the index crosses the 63-to-0 wrap. A design that dropped bit 7 at the wrap, or that let the object writes land in the background half, would read back wrong bytes afterwards. The bench reads the data register in the cycle straight after an index write, including when the other pair's index is written in between. A design that captured the preloaded byte late, or lost it, would return the previous data value. Mono-mode writes are followed by colour-mode reads of the index and by renderer reads of the targeted byte, which exposes any write that leaked through. One same-cycle renderer/CPU collision must return the old byte; a write-first memory would return the new one.

// File: rtl/palport_pkg.sv
package palport_pkg;
  localparam int NUM_PAIRS = 2;
  localparam int PAIR_W    = 1;

  // bit 1 picks the pair, bit 0 picks data (1) versus index (0)
  typedef enum logic [1:0] {
    SEL_BG_IDX = 2'd0,
    SEL_BG_DAT = 2'd1,
    SEL_OB_IDX = 2'd2,
    SEL_OB_DAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // port A: read-first read/write
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
  end

  // port B: read only, sees pre-write contents on collision
  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/pal_pair.sv
module pal_pair #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_idx,
  input  logic              wr_dat,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [IDX_W-1:0]  idx,
  output logic              auto_inc,
  output logic [DATA_W-1:0] data_view
);
  logic [DATA_W-1:0] data_q;
  logic              pend_q;   // data register still held in RAM output

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      auto_inc <= 1'b0;
      data_q   <= '0;
      pend_q   <= 1'b0;
    end else if (wr_idx) begin
      idx      <= wdata[IDX_W-1:0];
      auto_inc <= wdata[DATA_W-1];
      pend_q   <= 1'b1;
    end else if (wr_dat) begin
      data_q <= wdata;
      pend_q <= 1'b0;
      if (auto_inc) idx <= idx + 1'b1;
    end else if (pend_q) begin
      data_q <= ram_rdata;
      pend_q <= 1'b0;
    end
  end

  assign data_view = pend_q ? ram_rdata : data_q;
endmodule

// File: rtl/pal_port.sv
module pal_port
  import palport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              color_mode,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  input  logic              rnd_rd,
  input  logic [IDX_W:0]    rnd_addr,
  output logic [DATA_W-1:0] rnd_data,
  output logic              rnd_valid
);
  localparam int AW  = IDX_W + PAIR_W;
  localparam int PAD = DATA_W - IDX_W - 1;

  logic              act_wr;
  logic [PAIR_W-1:0] sel_pair;
  logic              sel_data;
  logic [IDX_W-1:0]  idx_a   [NUM_PAIRS];
  logic              auto_a  [NUM_PAIRS];
  logic [DATA_W-1:0] view_a  [NUM_PAIRS];
  logic [DATA_W-1:0] a_rdata;
  logic [AW-1:0]     a_addr;

  assign act_wr   = cpu_wr & color_mode;
  assign sel_pair = cpu_sel[1];
  assign sel_data = cpu_sel[0];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic hit;
    assign hit = act_wr && (sel_pair == PAIR_W'(p));
    pal_pair #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_pair (
      .clk       (clk),
      .rst       (rst),
      .wr_idx    (hit && !sel_data),
      .wr_dat    (hit && sel_data),
      .wdata     (cpu_wdata),
      .ram_rdata (a_rdata),
      .idx       (idx_a[p]),
      .auto_inc  (auto_a[p]),
      .data_view (view_a[p])
    );
  end

  assign a_addr = sel_data ? {sel_pair, idx_a[sel_pair]}
                           : {sel_pair, cpu_wdata[IDX_W-1:0]};

  pal_ram #(.AW(AW), .DW(DATA_W)) u_ram (
    .clk     (clk),
    .a_en    (act_wr),
    .a_we    (act_wr && sel_data),
    .a_addr  (a_addr),
    .a_wdata (cpu_wdata),
    .a_rdata (a_rdata),
    .b_en    (rnd_rd),
    .b_addr  (rnd_addr),
    .b_rdata (rnd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata  <= '0;
      cpu_rvalid <= 1'b0;
      rnd_valid  <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_rd;
      rnd_valid  <= rnd_rd;
      if (cpu_rd) begin
        if (!color_mode)   cpu_rdata <= '1;
        else if (sel_data) cpu_rdata <= view_a[sel_pair];
        else cpu_rdata <= {auto_a[sel_pair], {PAD{1'b0}}, idx_a[sel_pair]};
      end
    end
  end
endmodule

// File: rtl/pal_port_chk.sv
module pal_port_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              color_mode,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [1:0]        cpu_sel,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              cpu_rvalid,
  input logic              rnd_rd,
  input logic              rnd_valid
);
  localparam int PAD = DATA_W - IDX_W - 1;
  localparam logic [DATA_W-1:0] IDX_MASK = {1'b1, {PAD{1'b0}}, {IDX_W{1'b1}}};

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_rvalid && !rnd_valid && cpu_rdata == '0));

  assert_rvalid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_rd |=> cpu_rvalid);

  assert_no_stray_rvalid_R8: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> !cpu_rvalid);

  assert_mono_reads_ones_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !color_mode) |=> cpu_rdata == '1);

  assert_idx_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && color_mode && !cpu_sel[0]) |=> cpu_rdata[DATA_W-2:IDX_W] == '0);

  assert_idx_readback_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_wr && color_mode && !cpu_sel[0]) && cpu_rd && color_mode &&
     !cpu_wr && cpu_sel == $past(cpu_sel))
    |=> cpu_rdata == ($past(cpu_wdata, 2) & IDX_MASK));

  assert_rnd_valid_R9: assert property (@(posedge clk) disable iff (rst)
    rnd_rd |=> rnd_valid);

  assert_rnd_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !rnd_rd |=> !rnd_valid);
endmodule

bind pal_port pal_port_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .color_mode (color_mode),
  .cpu_wr     (cpu_wr),
  .cpu_rd     (cpu_rd),
  .cpu_sel    (cpu_sel),
  .cpu_wdata  (cpu_wdata),
  .cpu_rdata  (cpu_rdata),
  .cpu_rvalid (cpu_rvalid),
  .rnd_rd     (rnd_rd),
  .rnd_valid  (rnd_valid)
);

// File: tb/pal_port_bench.sv
module pal_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       color_mode = 1'b1;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic [1:0] cpu_sel = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       cpu_rvalid;
  logic       rnd_rd = 1'b0;
  logic [6:0] rnd_addr = 7'd0;
  logic [7:0] rnd_data;
  logic       rnd_valid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rexp_q[$];
  string      rtag_q[$];

  // requirement-level model
  logic [7:0] m_mem [128];
  logic [5:0] m_idx [2];
  logic       m_auto [2];
  logic [7:0] m_data [2];

  always #2 clk = ~clk;

  pal_port u_pal_port (
    .clk(clk), .rst(rst), .color_mode(color_mode),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .rnd_rd(rnd_rd), .rnd_addr(rnd_addr), .rnd_data(rnd_data),
    .rnd_valid(rnd_valid)
  );

  task automatic model_write(input logic [1:0] s, input logic [7:0] d);
    int p;
    p = int'(s[1]);
    if (!color_mode) return;
    if (!s[0]) begin
      m_idx[p]  = d[5:0];
      m_auto[p] = d[7];
      m_data[p] = m_mem[p*64 + int'(d[5:0])];
    end else begin
      m_mem[p*64 + int'(m_idx[p])] = d;
      m_data[p] = d;
      if (m_auto[p]) m_idx[p] = m_idx[p] + 6'd1;
    end
  endtask

  function automatic logic [7:0] model_read(input logic [1:0] s);
    int p;
    p = int'(s[1]);
    if (!color_mode) return 8'hFF;
    if (s[0]) return m_data[p];
    return {m_auto[p], 1'b0, m_idx[p]};
  endfunction

  task automatic cpu_write(input logic [1:0] s, input logic [7:0] d);
    model_write(s, d);
    cpu_wr = 1'b1; cpu_sel = s; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] s, input string tag);
    exp_q.push_back(model_read(s));
    tag_q.push_back(tag);
    cpu_rd = 1'b1; cpu_sel = s;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic rnd_read(input logic [6:0] a, input string tag);
    rexp_q.push_back(m_mem[int'(a)]);
    rtag_q.push_back(tag);
    rnd_rd = 1'b1; rnd_addr = a;
    @(negedge clk);
    rnd_rd = 1'b0;
  endtask

  // same-cycle background data write and renderer read of that byte
  task automatic collide(input logic [7:0] d);
    logic [6:0] a;
    a = {1'b0, m_idx[0]};
    rexp_q.push_back(m_mem[int'(a)]);
    rtag_q.push_back("R10");
    model_write(2'd1, d);
    cpu_wr = 1'b1; cpu_sel = 2'd1; cpu_wdata = d;
    rnd_rd = 1'b1; rnd_addr = a;
    @(negedge clk);
    cpu_wr = 1'b0; rnd_rd = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && cpu_rvalid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R8: unexpected cpu_rvalid, actual %02h expected none", cpu_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (cpu_rdata !== e) begin
          mismatched++;
          $display("FAIL %s: cpu_rdata actual %02h expected %02h", t, cpu_rdata, e);
        end
      end
    end
    if (!rst && rnd_valid) begin
      compared++;
      if (rexp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R9: unexpected rnd_valid, actual %02h expected none", rnd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = rexp_q.pop_front();
        t = rtag_q.pop_front();
        if (rnd_data !== e) begin
          mismatched++;
          $display("FAIL %s: rnd_data actual %02h expected %02h", t, rnd_data, e);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    mismatched++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_idx[i] = 6'd0; m_auto[i] = 1'b0; m_data[i] = 8'd0;
    end
    for (int i = 0; i < 128; i++) m_mem[i] = 8'd0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    if (cpu_rvalid !== 1'b0 || rnd_valid !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: valids after reset actual %b%b expected 00", cpu_rvalid, rnd_valid);
    end
    compared++;

    // R1: all four registers read zero after reset
    cpu_read(2'd0, "R1");
    cpu_read(2'd1, "R1");
    cpu_read(2'd2, "R1");
    cpu_read(2'd3, "R1");

    // R5/R6: fill both halves by streaming, crossing the 63->0 wrap
    cpu_write(2'd0, 8'h80);
    for (int i = 0; i < 64; i++) cpu_write(2'd1, 8'(i * 7 + 3));
    cpu_read(2'd0, "R5");
    cpu_write(2'd2, 8'h80);
    for (int i = 0; i < 64; i++) cpu_write(2'd3, 8'(i * 13 + 8'h40));
    cpu_read(2'd2, "R5");
    rnd_read(7'd0,   "R6");
    rnd_read(7'd64,  "R6");
    rnd_read(7'd63,  "R6");
    rnd_read(7'd127, "R6");
    rnd_read(7'd17,  "R9");

    // R2/R3: index write masks bit 6 and preloads the data register
    cpu_write(2'd0, 8'h43);
    cpu_read(2'd0, "R2");
    cpu_write(2'd0, 8'h05);
    cpu_read(2'd1, "R3");
    // other pair's index written in between
    cpu_write(2'd0, 8'h0A);
    cpu_write(2'd2, 8'h21);
    cpu_read(2'd1, "R3");
    cpu_read(2'd3, "R3");

    // R4/R5: data write without auto-increment keeps the index
    cpu_write(2'd0, 8'h09);
    cpu_write(2'd1, 8'h5A);
    cpu_read(2'd1, "R4");
    cpu_read(2'd0, "R5");
    rnd_read(7'd9, "R4");

    // R5: wrap keeps bit 7, object half
    cpu_write(2'd2, 8'hBF);
    cpu_write(2'd3, 8'h11);
    cpu_read(2'd2, "R5");
    cpu_read(2'd3, "R4");
    rnd_read(7'd127, "R6");

    // R10: collision returns the old byte, then the new one
    cpu_write(2'd0, 8'h14);
    collide(8'hC3);
    rnd_read(7'd20, "R10");

    // R7: mono mode ignores writes, reads all ones
    cpu_write(2'd0, 8'h02);
    color_mode = 1'b0;
    cpu_write(2'd0, 8'h85);
    cpu_write(2'd1, 8'h77);
    cpu_write(2'd2, 8'h30);
    cpu_read(2'd0, "R7");
    cpu_read(2'd1, "R7");
    cpu_read(2'd3, "R7");
    color_mode = 1'b1;
    cpu_read(2'd0, "R7");
    cpu_read(2'd1, "R7");
    cpu_read(2'd2, "R7");
    rnd_read(7'd2, "R7");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0 || rexp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R8: pending results actual %0d expected 0", exp_q.size() + rexp_q.size());
    end
    summary();
  end
endmodule